// File: doc/BRIEF.md
# Exception Context Save Registers

This unit holds the processor state that an interrupt handler needs in order to return. A non-maskable interrupt (NMI) strobe makes it store the address of the next instruction and the current status word in a dedicated pair of save registers. Any accepted event also stores a coded cause in a cause register. That register is split in two halves. The upper half takes NMI codes and the lower half takes codes from maskable interrupts and exceptions.

Software reaches the three registers through a register-index read port and a write port. Reserved upper bits of the two save registers are stored as zero and always read back as zero. The cause register cannot be changed by software. There is only one save set, so a handler that allows nesting must copy the saved context out before a second NMI arrives.

Top module: `exc_ctx_regs`

## Requirements
- R1: When `nmi_take_i` is high at a rising clock edge, bits 25:0 of `nmi_pc_i` are stored in the PC-save register (index 0). The value is readable from the next cycle on.
- R2: When `nmi_take_i` is high at a rising clock edge, bits 7:0 of `psw_i` are stored in the PSW-save register (index 1).
- R3: Bits 31:26 of the PC-save register and bits 31:8 of the PSW-save register always read as zero, whatever value was captured or written.
- R4: An NMI loads `nmi_code_i` into cause bits 31:16 and leaves cause bits 15:0 unchanged.
- R5: An exception strobe loads `exc_code_i` into cause bits 15:0 and leaves bits 31:16 unchanged. When both strobes are high in the same cycle, both halves are loaded.
- R6: The cause register (index 2) is read-only. A software write to index 2 does not change it.
- R7: After reset, indices 0, 1 and 2 all read zero.
- R8: A second NMI overwrites the previously saved PC, PSW and NMI code.
- R9: A software write to index 0 or 1 stores the write data with the reserved bits cleared. It is readable in the next cycle.
- R10: When an NMI capture and a software write to the same save register fall in the same cycle, the captured value is kept.
- R11: A read of any index from 3 to 31 returns zero, and a write to such an index changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_take_i | input | 1 | NMI accepted this cycle |
| nmi_pc_i | input | 32 | Address of the next instruction |
| psw_i | input | 32 | Current status word |
| nmi_code_i | input | 16 | NMI cause code |
| exc_take_i | input | 1 | Maskable interrupt or exception accepted this cycle |
| exc_code_i | input | 16 | Exception or interrupt cause code |
| sr_wr_en_i | input | 1 | Software register write strobe |
| sr_wr_idx_i | input | 5 | Write register index |
| sr_wr_data_i | input | 32 | Write data |
| sr_rd_idx_i | input | 5 | Read register index |
| sr_rd_data_o | output | 32 | Read data, combinational from the index |

## Verification
The assertions assume that the capture strobes and write strobes are clean, single-cycle, synchronous pulses. They also assume that the read index selects a register whose contents did not change at the same edge. The stimulus drives every strobe at the falling edge and holds it for one cycle. Each read is issued in a cycle with all strobes low, so the register read is not being updated in that cycle. Collisions between a software write and an NMI capture are produced on purpose and only through the write port, which keeps the hardware capture path the single source of the expected value.

// File: rtl/exc_ctx_pkg.sv
package exc_ctx_pkg;
  localparam int unsigned XLEN     = 32;
  localparam int unsigned PC_BITS  = 26;
  localparam int unsigned PSW_BITS = 8;
  localparam int unsigned CODE_W   = 16;
  localparam int unsigned IDX_W    = 5;

  localparam logic [IDX_W-1:0] IDX_NMI_PC  = 5'd0;
  localparam logic [IDX_W-1:0] IDX_NMI_PSW = 5'd1;
  localparam logic [IDX_W-1:0] IDX_CAUSE   = 5'd2;
endpackage

// File: rtl/ctx_save_reg.sv
module ctx_save_reg #(
  parameter int unsigned W    = 32,
  parameter int unsigned KEEP = 26
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hw_en_i,
  input  logic [W-1:0] hw_d_i,
  input  logic         sw_en_i,
  input  logic [W-1:0] sw_d_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] KEEP_MASK = W'((64'd1 << KEEP) - 64'd1);

  logic [W-1:0] q_q;

  // hardware capture has priority over a software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (hw_en_i) q_q <= hw_d_i & KEEP_MASK;
    else if (sw_en_i) q_q <= sw_d_i & KEEP_MASK;
  end

  assign q_o = q_q;

  a_r1_r2_hw_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_en_i |=> q_o[KEEP-1:0] == $past(hw_d_i[KEEP-1:0]));
  a_r10_hw_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_en_i && sw_en_i) |=> q_o[KEEP-1:0] == $past(hw_d_i[KEEP-1:0]));
  a_r9_sw_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_i && !hw_en_i) |=> q_o[KEEP-1:0] == $past(sw_d_i[KEEP-1:0]));
  a_r3_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o & ~KEEP_MASK) == '0);
  a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw_en_i && !sw_en_i) |=> $stable(q_o));
endmodule

// File: rtl/ctx_cause_reg.sv
module ctx_cause_reg #(
  parameter int unsigned CODE_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  nmi_en_i,
  input  logic [CODE_W-1:0]     nmi_code_i,
  input  logic                  exc_en_i,
  input  logic [CODE_W-1:0]     exc_code_i,
  output logic [2*CODE_W-1:0]   q_o
);
  logic [CODE_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (nmi_en_i) hi_q <= nmi_code_i;
      if (exc_en_i) lo_q <= exc_code_i;
    end
  end

  assign q_o = {hi_q, lo_q};

  a_r4_nmi_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_en_i |=> q_o[2*CODE_W-1:CODE_W] == $past(nmi_code_i));
  a_r4_lower_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_en_i && !exc_en_i) |=> q_o[CODE_W-1:0] == $past(q_o[CODE_W-1:0]));
  a_r5_exc_lower: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_en_i |=> q_o[CODE_W-1:0] == $past(exc_code_i));
  a_r5_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_en_i && !nmi_en_i) |=> q_o[2*CODE_W-1:CODE_W] == $past(q_o[2*CODE_W-1:CODE_W]));
endmodule

// File: rtl/exc_ctx_regs.sv
module exc_ctx_regs
  import exc_ctx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmi_take_i,
  input  logic [XLEN-1:0]   nmi_pc_i,
  input  logic [XLEN-1:0]   psw_i,
  input  logic [CODE_W-1:0] nmi_code_i,
  input  logic              exc_take_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              sr_wr_en_i,
  input  logic [IDX_W-1:0]  sr_wr_idx_i,
  input  logic [XLEN-1:0]   sr_wr_data_i,
  input  logic [IDX_W-1:0]  sr_rd_idx_i,
  output logic [XLEN-1:0]   sr_rd_data_o
);
  logic [XLEN-1:0] pc_q, psw_q, cause_q;
  logic            sw_pc_en, sw_psw_en;

  assign sw_pc_en  = sr_wr_en_i && (sr_wr_idx_i == IDX_NMI_PC);
  assign sw_psw_en = sr_wr_en_i && (sr_wr_idx_i == IDX_NMI_PSW);

  ctx_save_reg #(.W(XLEN), .KEEP(PC_BITS)) u_pc_save (
    .clk_i, .rst_ni,
    .hw_en_i(nmi_take_i), .hw_d_i(nmi_pc_i),
    .sw_en_i(sw_pc_en),   .sw_d_i(sr_wr_data_i),
    .q_o(pc_q)
  );

  ctx_save_reg #(.W(XLEN), .KEEP(PSW_BITS)) u_psw_save (
    .clk_i, .rst_ni,
    .hw_en_i(nmi_take_i), .hw_d_i(psw_i),
    .sw_en_i(sw_psw_en),  .sw_d_i(sr_wr_data_i),
    .q_o(psw_q)
  );

  // no software path into the cause register
  ctx_cause_reg #(.CODE_W(CODE_W)) u_cause (
    .clk_i, .rst_ni,
    .nmi_en_i(nmi_take_i), .nmi_code_i(nmi_code_i),
    .exc_en_i(exc_take_i), .exc_code_i(exc_code_i),
    .q_o(cause_q)
  );

  always_comb begin
    unique case (sr_rd_idx_i)
      IDX_NMI_PC:  sr_rd_data_o = pc_q;
      IDX_NMI_PSW: sr_rd_data_o = psw_q;
      IDX_CAUSE:   sr_rd_data_o = cause_q;
      default:     sr_rd_data_o = '0;
    endcase
  end

  a_r6_cause_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_wr_en_i && !nmi_take_i && !exc_take_i) |=> $stable(cause_q));
  a_r11_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_rd_idx_i > IDX_CAUSE) |-> sr_rd_data_o == '0);
  a_r3_pc_port_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_rd_idx_i == IDX_NMI_PC) |-> sr_rd_data_o[XLEN-1:PC_BITS] == '0);
  a_r8_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_take_i |=> cause_q[XLEN-1:CODE_W] == $past(nmi_code_i));
endmodule

// File: tb/tb_exc_ctx_regs.sv
module tb_exc_ctx_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_take = 1'b0, exc_take = 1'b0, wr_en = 1'b0;
  logic [31:0] nmi_pc = '0, psw = '0, wr_data = '0, rd_data;
  logic [15:0] nmi_code = '0, exc_code = '0;
  logic [4:0]  wr_idx = '0, rd_idx = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    int          idx;
    string       tag;
  } item_t;
  item_t sb_q[$];

  logic [31:0] m_pc = '0, m_psw = '0, m_cause = '0;

  always #10 clk = ~clk;

  exc_ctx_regs dut (
    .clk_i(clk), .rst_ni(rst_n),
    .nmi_take_i(nmi_take), .nmi_pc_i(nmi_pc), .psw_i(psw), .nmi_code_i(nmi_code),
    .exc_take_i(exc_take), .exc_code_i(exc_code),
    .sr_wr_en_i(wr_en), .sr_wr_idx_i(wr_idx), .sr_wr_data_i(wr_data),
    .sr_rd_idx_i(rd_idx), .sr_rd_data_o(rd_data)
  );

  function automatic logic [31:0] model_rd(int idx);
    case (idx)
      0: return m_pc;
      1: return m_psw;
      2: return m_cause;
      default: return 32'h0;
    endcase
  endfunction

  // one stimulus cycle; the model follows the requirements
  task automatic drive(bit n, logic [31:0] pc, logic [31:0] ps, logic [15:0] nc,
                       bit e, logic [15:0] ec, bit w, logic [4:0] wi, logic [31:0] wd);
    @(negedge clk);
    nmi_take = n; nmi_pc = pc; psw = ps; nmi_code = nc;
    exc_take = e; exc_code = ec;
    wr_en = w; wr_idx = wi; wr_data = wd;
    if (w && wi == 5'd0) m_pc  = wd & 32'h03FF_FFFF;   // R9
    if (w && wi == 5'd1) m_psw = wd & 32'h0000_00FF;   // R9
    if (n) begin                                        // R1 R2 R4 R10
      m_pc  = pc & 32'h03FF_FFFF;
      m_psw = ps & 32'h0000_00FF;
      m_cause[31:16] = nc;
    end
    if (e) m_cause[15:0] = ec;                          // R5
  endtask

  task automatic check_rd(int idx, string tag);
    item_t it;
    @(negedge clk);
    nmi_take = 0; exc_take = 0; wr_en = 0;
    rd_idx = 5'(idx);
    it.exp = model_rd(idx); it.idx = idx; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compares one pending item after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (rd_data !== it.exp) begin
          errors++;
          $display("FAIL %s idx=%0d actual=%08h expected=%08h", it.tag, it.idx, rd_data, it.exp);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 reset values
    check_rd(0, "R7");
    check_rd(1, "R7");
    check_rd(2, "R7");
    check_rd(7, "R11");
    // R1 R2 R3 R4 NMI capture with reserved bits set at the inputs
    drive(1, 32'hFFFF_1234, 32'hABCD_EF5A, 16'h00C0, 0, 16'h0, 0, 5'd0, 32'h0);
    check_rd(0, "R1_R3");
    check_rd(1, "R2_R3");
    check_rd(2, "R4");
    // R5 exception into lower half only
    drive(0, 32'h0, 32'h0, 16'h0, 1, 16'h0031, 0, 5'd0, 32'h0);
    check_rd(2, "R5");
    check_rd(0, "R5_pc_kept");
    // R5 both strobes together
    drive(1, 32'h0000_0444, 32'h0000_0011, 16'h00D1, 1, 16'h0062, 0, 5'd0, 32'h0);
    check_rd(2, "R5_both");
    // R8 second NMI overwrites
    drive(1, 32'h02AA_AAAA, 32'h0000_00F0, 16'h0E55, 0, 16'h0, 0, 5'd0, 32'h0);
    check_rd(0, "R8");
    check_rd(1, "R8");
    check_rd(2, "R8");
    // R9 R3 software writes masked
    drive(0, 32'h0, 32'h0, 16'h0, 0, 16'h0, 1, 5'd0, 32'hFFFF_FFFF);
    check_rd(0, "R9_R3");
    drive(0, 32'h0, 32'h0, 16'h0, 0, 16'h0, 1, 5'd1, 32'h1234_5687);
    check_rd(1, "R9_R3");
    // R6 cause write ignored
    drive(0, 32'h0, 32'h0, 16'h0, 0, 16'h0, 1, 5'd2, 32'hDEAD_BEEF);
    check_rd(2, "R6");
    // R11 unmapped write, then read all
    drive(0, 32'h0, 32'h0, 16'h0, 0, 16'h0, 1, 5'd3, 32'h5555_5555);
    check_rd(3, "R11");
    check_rd(31, "R11");
    check_rd(0, "R11_pc_kept");
    check_rd(1, "R11_psw_kept");
    check_rd(2, "R11_cause_kept");
    // R10 collision: capture beats write
    drive(1, 32'h0111_2222, 32'h0000_0033, 16'h0077, 0, 16'h0, 1, 5'd0, 32'h0000_0ABC);
    check_rd(0, "R10");
    drive(1, 32'h0000_0010, 32'h0000_0044, 16'h0078, 0, 16'h0, 1, 5'd1, 32'h0000_00EE);
    check_rd(1, "R10");
    check_rd(2, "R10_cause");
    // reset again clears all (R7)
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_pc = '0; m_psw = '0; m_cause = '0;
    check_rd(0, "R7_rereset");
    check_rd(2, "R7_rereset");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule